// File: doc/BRIEF.md
# Six-Bit I/O Port with Stop-Mode Pin Retention

This block is a six-pin general-purpose I/O port for a small microcontroller. Software reaches it through a simple register bus with four word addresses. It holds an output value register, a direction register and a pullup enable register, and a power status word. Each pad is modelled by four signals: output data, output enable, pullup enable and the sampled input value. The block decides what every pad drives and what every read returns.

A low-power controller presents the stop state on a two-bit level input. The light stop leaves all logic powered, so nothing changes. The partial power-down freezes every pad in retention latches at the value it had just before entry, and the port registers are treated as unpowered. On the way back a recovery flag reads 1, and the pads stay frozen until software writes 1 to an acknowledge bit. The deepest stop clears everything and turns every pad off, so the port comes back as it was after power-on.

Top module: `gpio_retain_port`

## Requirements
- R1: After reset, addresses 1, 2 and 3 read 0, and padOut, padOe and padPu are all 0. Address 0 then reads the pad input on bits 0, 1, 2, 3 and 5, and 0 on bit 4.
- R2: Address 0 reads bits 0 to 3 from the output register when the matching direction bit is 1, and from padIn when it is 0. Bits 7 and 6 always read 0.
- R3: Address 0 bit 5 always returns padIn[5], whatever direction bit 5 holds.
- R4: Address 0 bit 4 always returns the stored output register bit 4, whatever direction bit 4 holds.
- R5: In run mode (stopMode = 0), a bus write to address 0, 1 or 2 sets the output, direction or pullup register at the next clock edge. Outside stop and retention, padOut, padOe and padPu follow those three registers.
- R6: In light stop (stopMode = 1) the pads and all registers keep their values. Bus writes are ignored in every stop mode (stopMode other than 0).
- R7: In partial power-down (stopMode = 2), the pads keep the values they had in the cycle before entry. The output, direction and pullup registers read 0 after wake-up.
- R8: After partial power-down, address 3 bit 0 (the recovery flag) reads 1. The pads stay frozen until the acknowledge, and run-mode writes made meanwhile update the registers but not the pads.
- R9: In run mode, a write to address 3 with bit 1 set clears the recovery flag. From the next cycle the pads follow the registers again. A write to address 3 with bit 1 clear has no effect, and bit 1 always reads 0.
- R10: While stopMode = 3, padOut, padOe and padPu are all 0. After it ends, all registers, the recovery flag and retention read as after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| busAddr | input | 2 | Register address: 0 output/pin view, 1 direction, 2 pullup, 3 power status |
| busWrEn | input | 1 | Write strobe, applied at the clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| stopMode | input | 2 | 0 run, 1 light stop, 2 partial power-down, 3 deep stop |
| padIn | input | 6 | Sampled pad input levels |
| padOut | output | 6 | Pad output data |
| padOe | output | 6 | Pad output buffer enable |
| padPu | output | 6 | Pad pullup enable |

## Verification
Some properties are checked on every cycle. Deep stop always turns the pads off. The pads do not move across a light stop. The pads stay frozen during partial power-down and in the cycle of wake-up from it. The recovery flag reads set at that wake-up, and the direction register reads zero after a deep stop. Only the bench scenarios can show the rest. These are the per-bit read sources in both directions, writes made during retention reaching the registers but not the pads, a zero acknowledge changing nothing, and a real acknowledge releasing the pads one cycle later. A reference model checks all of this across random sequences of stop modes.

// File: rtl/gpio_retain_pkg.sv
package gpio_retain_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_LIGHT   = 2'd1,
    MODE_PARTIAL = 2'd2,
    MODE_DEEP    = 2'd3
  } stop_mode_e;

  localparam logic [1:0] ADDR_VIEW = 2'd0;
  localparam logic [1:0] ADDR_DIR  = 2'd1;
  localparam logic [1:0] ADDR_PULL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrPull;
    logic clrRegs;
    logic capture;
    logic holdOn;
    logic forceOff;
  } port_strobe_t;
endpackage

// File: rtl/gpio_retain_ctrl.sv
module gpio_retain_ctrl
  import gpio_retain_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   stopMode,
  input  logic [1:0]   busAddr,
  input  logic         busWrEn,
  input  logic         ackBit,
  output port_strobe_t strobe,
  output logic         recFlag
);
  stop_mode_e mode;
  logic holdActive;
  logic wrOk;
  logic ackWr;

  always_comb begin
    mode          = stop_mode_e'(stopMode);
    wrOk          = busWrEn && (mode == MODE_RUN);
    ackWr         = wrOk && (busAddr == ADDR_STAT) && ackBit;
    strobe.wrData   = wrOk && (busAddr == ADDR_VIEW);
    strobe.wrDir    = wrOk && (busAddr == ADDR_DIR);
    strobe.wrPull   = wrOk && (busAddr == ADDR_PULL);
    strobe.clrRegs  = (mode == MODE_PARTIAL) || (mode == MODE_DEEP);
    strobe.capture  = (mode == MODE_PARTIAL) && !holdActive;
    strobe.holdOn   = holdActive;
    strobe.forceOff = (mode == MODE_DEEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdActive <= 1'b0;
      recFlag    <= 1'b0;
    end else if (mode == MODE_DEEP) begin
      holdActive <= 1'b0;
      recFlag    <= 1'b0;
    end else if (mode == MODE_PARTIAL) begin
      holdActive <= 1'b1;
      recFlag    <= 1'b1;
    end else if (ackWr) begin
      holdActive <= 1'b0;
      recFlag    <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_retain_datapath.sv
module gpio_retain_datapath
  import gpio_retain_pkg::*;
#(
  parameter int PORT_W     = 6,
  parameter int DATA_W     = 8,
  parameter int LIVE_BIT   = 5,
  parameter int STORED_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  port_strobe_t      strobe,
  input  logic [1:0]        busAddr,
  input  logic [PORT_W-1:0] wrVal,
  input  logic [PORT_W-1:0] padIn,
  input  logic              recFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPu
);
  logic [PORT_W-1:0] dataReg, dirReg, pullReg;
  logic [PORT_W-1:0] latOut, latOe, latPu;
  logic [PORT_W-1:0] pinView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      pullReg <= '0;
    end else if (strobe.clrRegs) begin
      dataReg <= '0;
      dirReg  <= '0;
      pullReg <= '0;
    end else begin
      if (strobe.wrData) dataReg <= wrVal;
      if (strobe.wrDir)  dirReg  <= wrVal;
      if (strobe.wrPull) pullReg <= wrVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latOut <= '0;
      latOe  <= '0;
      latPu  <= '0;
    end else if (strobe.capture) begin
      latOut <= dataReg;
      latOe  <= dirReg;
      latPu  <= pullReg;
    end
  end

  always_comb begin
    if (strobe.forceOff) begin
      padOut = '0;
      padOe  = '0;
      padPu  = '0;
    end else if (strobe.holdOn) begin
      padOut = latOut;
      padOe  = latOe;
      padPu  = latPu;
    end else begin
      padOut = dataReg;
      padOe  = dirReg;
      padPu  = pullReg;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_view
    if (i == LIVE_BIT) begin : g_live
      assign pinView[i] = padIn[i];
    end else if (i == STORED_BIT) begin : g_stored
      assign pinView[i] = dataReg[i];
    end else begin : g_mux
      assign pinView[i] = dirReg[i] ? dataReg[i] : padIn[i];
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_VIEW: rdData = DATA_W'(pinView);
      ADDR_DIR:  rdData = DATA_W'(dirReg);
      ADDR_PULL: rdData = DATA_W'(pullReg);
      default:   rdData = DATA_W'(recFlag);
    endcase
  end
endmodule

// File: rtl/gpio_retain_port.sv
module gpio_retain_port
  import gpio_retain_pkg::*;
#(
  parameter int PORT_W     = 6,
  parameter int DATA_W     = 8,
  parameter int LIVE_BIT   = 5,
  parameter int STORED_BIT = 4,
  parameter int ACK_BIT    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [1:0]        stopMode,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPu
);
  port_strobe_t strobe;
  logic recFlag;

  gpio_retain_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stopMode (stopMode),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .ackBit   (busWrData[ACK_BIT]),
    .strobe   (strobe),
    .recFlag  (recFlag)
  );

  gpio_retain_datapath #(
    .PORT_W     (PORT_W),
    .DATA_W     (DATA_W),
    .LIVE_BIT   (LIVE_BIT),
    .STORED_BIT (STORED_BIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busAddr (busAddr),
    .wrVal   (busWrData[PORT_W-1:0]),
    .padIn   (padIn),
    .recFlag (recFlag),
    .rdData  (busRdData),
    .padOut  (padOut),
    .padOe   (padOe),
    .padPu   (padPu)
  );
endmodule

// File: rtl/gpio_retain_port_chk.sv
module gpio_retain_port_chk #(
  parameter int PORT_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic [1:0]        stopMode,
  input logic [PORT_W-1:0] padOut,
  input logic [PORT_W-1:0] padOe,
  input logic [PORT_W-1:0] padPu
);
  // R10
  deep_pins_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode == 2'd3) |-> (padOut == '0 && padOe == '0 && padPu == '0));

  // R6
  light_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stopMode) == 2'd1 && stopMode == 2'd1)
      |-> ($stable(padOut) && $stable(padOe) && $stable(padPu)));

  // R7
  partial_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stopMode) == 2'd2 && stopMode != 2'd3)
      |-> ($stable(padOut) && $stable(padOe) && $stable(padPu)));

  // R8
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stopMode) == 2'd2 && stopMode == 2'd0 && busAddr == 2'd3)
      |-> busRdData[0]);

  // R10
  deep_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stopMode) == 2'd3 && stopMode == 2'd0 && busAddr == 2'd1)
      |-> (busRdData == '0));
endmodule

bind gpio_retain_port gpio_retain_port_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .stopMode  (stopMode),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPu     (padPu)
);

// File: tb/gpio_retain_port_test.sv
module gpio_retain_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [1:0] stopMode = '0;
  logic [5:0] padIn = '0;
  logic [5:0] padOut, padOe, padPu;

  int checks = 0;
  int fails = 0;

  logic [5:0] mData = '0, mDir = '0, mPull = '0;
  logic [5:0] lOut = '0, lOe = '0, lPu = '0;
  logic mHold = 1'b0, mFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_retain_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .stopMode(stopMode),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPu(padPu)
  );

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a, input logic [5:0] pin);
    logic [7:0] v;
    v = '0;
    case (a)
      2'd0: begin
        for (int i = 0; i < 4; i++) v[i] = mDir[i] ? mData[i] : pin[i];
        v[4] = mData[4];
        v[5] = pin[5];
      end
      2'd1: v = {2'b00, mDir};
      2'd2: v = {2'b00, mPull};
      default: v = {7'd0, mFlag};
    endcase
    return v;
  endfunction

  function automatic logic [17:0] expPads(input logic [1:0] m);
    if (m == 2'd3) return '0;
    if (mHold) return {lOut, lOe, lPu};
    return {mData, mDir, mPull};
  endfunction

  function automatic string padTag(input logic [1:0] m);
    if (m == 2'd3) return "R10";
    if (mHold) return "R7/R8";
    if (m == 2'd1) return "R6";
    return "R5";
  endfunction

  task automatic cyc(input logic [1:0] m, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input logic [5:0] pin);
    @(negedge clk);
    stopMode = m; busWrEn = w; busAddr = a; busWrData = d; padIn = pin;
    #1;
    chk((a == 2'd0) ? "R2/R3/R4 read" : "R9 read", {10'd0, busRdData}, {10'd0, expRead(a, pin)});
    chk(padTag(m), {padOut, padOe, padPu}, expPads(m));
    @(posedge clk);
    if (m == 2'd3) begin
      mData = '0; mDir = '0; mPull = '0; mHold = 1'b0; mFlag = 1'b0;
    end else if (m == 2'd2) begin
      if (!mHold) begin lOut = mData; lOe = mDir; lPu = mPull; mHold = 1'b1; end
      mData = '0; mDir = '0; mPull = '0; mFlag = 1'b1;
    end else if (m == 2'd0 && w) begin
      case (a)
        2'd0: mData = d[5:0];
        2'd1: mDir = d[5:0];
        2'd2: mPull = d[5:0];
        default: if (d[1]) begin mHold = 1'b0; mFlag = 1'b0; end
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      busAddr = a[1:0]; padIn = 6'b101101;
      #1;
      chk("R1 reset read", {10'd0, busRdData},
          (a == 0) ? 18'h0002D & 18'h0002F : 18'd0);
      chk("R1 reset pads", {padOut, padOe, padPu}, '0);
    end
    // R2 R3 R4 R5 directed configuration
    cyc(2'd0, 1'b1, 2'd1, 8'hFF & 8'b00100101, 6'b000000);
    cyc(2'd0, 1'b1, 2'd0, 8'b00011010, 6'b000000);
    cyc(2'd0, 1'b1, 2'd2, 8'b00001010, 6'b111111);
    cyc(2'd0, 1'b0, 2'd0, 8'h00, 6'b100000);
    cyc(2'd0, 1'b0, 2'd0, 8'h00, 6'b011111);
    // R3: bit 5 is an output yet reads the pin
    chk("R3 live bit", {17'd0, busRdData[5]}, 18'd0);
    // R4: bit 4 is an input yet reads the register (1)
    chk("R4 stored bit", {17'd0, busRdData[4]}, 18'd1);
    // random run traffic
    for (int i = 0; i < 300; i++)
      cyc(2'd0, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 2)), 8'($urandom), 6'($urandom));
    // R6 light stop with ignored writes
    for (int i = 0; i < 5; i++) cyc(2'd1, 1'b1, 2'd1, 8'($urandom), 6'($urandom));
    cyc(2'd0, 1'b0, 2'd1, 8'h00, 6'd0);
    // R7 partial stop with ignored writes
    for (int i = 0; i < 4; i++) cyc(2'd2, 1'b1, 2'd0, 8'($urandom), 6'($urandom));
    // R8 flag set on wake, registers cleared
    cyc(2'd0, 1'b0, 2'd3, 8'h00, 6'd0);
    cyc(2'd0, 1'b0, 2'd1, 8'h00, 6'd0);
    // R8 writes during retention reach registers only
    cyc(2'd0, 1'b1, 2'd1, 8'h3F, 6'd0);
    cyc(2'd0, 1'b1, 2'd0, 8'h15, 6'd0);
    // R9 zero acknowledge does nothing, then real acknowledge
    cyc(2'd0, 1'b1, 2'd3, 8'hFD, 6'd0);
    cyc(2'd0, 1'b0, 2'd3, 8'h00, 6'd0);
    cyc(2'd0, 1'b1, 2'd3, 8'h02, 6'd0);
    cyc(2'd0, 1'b0, 2'd3, 8'h00, 6'd0);
    chk("R9 released pads", {12'd0, padOe}, 18'h3F);
    // R10 deep stop
    for (int i = 0; i < 3; i++) cyc(2'd3, 1'b1, 2'd1, 8'h3F, 6'($urandom));
    cyc(2'd0, 1'b0, 2'd1, 8'h00, 6'd0);
    cyc(2'd0, 1'b0, 2'd3, 8'h00, 6'd0);
    // mixed random sequence across all modes
    for (int i = 0; i < 2000; i++) begin
      int r;
      logic [1:0] m;
      r = $urandom_range(0, 15);
      m = (r < 12) ? 2'd0 : (r == 12) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
      cyc(m, $urandom_range(0, 1) == 1, 2'($urandom), 8'($urandom), 6'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule